// File: doc/BRIEF.md
# Masked address window decoder

This block holds the configuration for one programmable address window and checks every bus cycle against it. Software sets the window one byte at a time through a small configuration port: a lower and an upper bound, an alias mask and a control byte. The control byte picks whether the window answers memory cycles or I/O cycles. It also sets the attributes that go along with a hit: forward to the ISA side, read prefetch allowed, write posting allowed, and a trap request.

For each offered cycle (address, memory-or-I/O type, read-or-write) the block compares the address against the bounds. Address bits selected by the alias mask are left out of the compare on both sides, so one window can repeat across the address space. In I/O mode a narrow decode can be chosen, which also requires the upper address bits to be zero. The hit flag and its qualifiers appear on registered outputs one clock after the cycle is offered. Claiming the cycle and moving its data are left to the surrounding logic.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset the sixteen configuration bytes read 00, FF, FF, FF, 00, 00, 00, 00, 03, 00, 00, 48, 00, 00, 00, 00 at offsets 0 to 15. With these values no cycle hits, because the upper bound is below the lower bound.
- R2: Offsets 0-3 hold the lower bound (byte 0 = bits 7:0), offsets 4-7 hold the upper bound, offsets 8-10 hold the 24-bit alias mask and offset 11 holds the control byte. A write takes effect on the clock edge where `cfgWe` is high, and `cfgRdata` shows the byte at `cfgOffset` with no delay. Offsets 12-15 read 0 and ignore writes.
- R3: Mask bits 1:0 always read 1 and ignore writes. Lower-bound bit 1 and upper-bound bits 1:0 always read 0.
- R4: Control byte layout: bit 7 = forward to ISA, bit 6 = memory window (0 = I/O), bit 3 = reads prefetchable, bit 2 = writes postable, bit 0 = trap enable. Bits 5, 4 and 1 read 0 and ignore writes.
- R5: When `busValid` is high, `winHit` goes high on the next clock if (addr & ~M) >= (lower & ~M) and (addr & ~M) <= (upper & ~M). Here M is the mask zero-extended to 32 bits. Both bounds are inclusive.
- R6: Address bits whose mask bit is 1 are left out of the compare, so the window repeats at every value of those bits. Address bits 31:24 cannot be masked.
- R7: Lower-bound bit 0 selects the I/O decode width: 0 = 16-bit decode, where a hit also needs address bits 31:16 to be zero; 1 = 32-bit decode. This bit reads back 0 while the window is in memory mode and has no effect on memory decode.
- R8: A cycle hits only if `busIsMem` equals control bit 6.
- R9: `prefetchOk` is high only for a hit on a memory read with bit 3 set. `postOk` is high only for a hit on a memory write with bit 2 set. Both stay low for I/O windows whatever bits 3 and 2 hold.
- R10: `isaFwd` goes high together with a hit when bit 7 is set. `trapReq` goes high together with a hit when bit 0 is set, and it stays high for only one clock for each offered cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgOffset | input | 4 | Configuration byte offset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 8 | Configuration write byte |
| cfgRdata | output | 8 | Configuration read byte at cfgOffset |
| busValid | input | 1 | A bus cycle is offered this clock |
| busAddr | input | 32 | Bus cycle address |
| busIsMem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| busIsWrite | input | 1 | 1 = write, 0 = read |
| winHit | output | 1 | Registered window hit |
| isaFwd | output | 1 | Hit is to be forwarded to the ISA side |
| prefetchOk | output | 1 | Hit read may be prefetched |
| postOk | output | 1 | Hit write may be posted |
| trapReq | output | 1 | One-clock trap request on a hit |

## Verification
The bench aims at addresses exactly on the inclusive bounds and one word outside them. A design with an off-by-one compare would miss the bounds or claim the neighbours. An aliased address is offered whose masked form lands inside the window, which catches a mask applied to only one side of the compare. I/O cycles are run with nonzero upper address bits under both decode widths, and memory-mode attribute bits are applied to I/O hits; a design that leaked either would raise a hit or a posting flag where none belongs. The hard-wired mask, bound and reserved control bits are written with ones and read back, which catches storage that should not exist.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam int ADDR_W     = 32;
  localparam int MASK_W     = 24;
  localparam int OFFS_W     = 4;
  localparam int NARROW_W   = 16;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int MASK_BYTES = MASK_W / 8;

  localparam int START_OFF = 0;
  localparam int STOP_OFF  = START_OFF + ADDR_BYTES;
  localparam int MASK_OFF  = STOP_OFF + ADDR_BYTES;
  localparam int CTRL_OFF  = MASK_OFF + MASK_BYTES;

  localparam int CB_ISA  = 7;
  localparam int CB_MEM  = 6;
  localparam int CB_PREF = 3;
  localparam int CB_POST = 2;
  localparam int CB_TRAP = 0;

  localparam logic [7:0] CTRL_KEEP  = 8'hCD;
  localparam logic [7:0] CTRL_RESET = 8'h48;
  localparam logic [7:0] START_B0_KEEP = 8'hFD;
  localparam logic [7:0] STOP_B0_KEEP  = 8'hFC;
  localparam logic [7:0] MASK_B0_SET   = 8'h03;

  typedef struct packed {
    logic [ADDR_W-1:0] start;
    logic [ADDR_W-1:0] stop;
    logic [MASK_W-1:0] mask;
    logic              isMem;
    logic              wideIo;
    logic              toIsa;
    logic              prefetch;
    logic              post;
    logic              trap;
  } win_cfg_t;
endpackage

// File: rtl/wdw_cfg_regs.sv
module wdw_cfg_regs
  import wdw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFFS_W-1:0] cfgOffset,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  output win_cfg_t          cfg
);
  logic [ADDR_W-1:0] startQ;
  logic [ADDR_W-1:0] stopQ;
  logic [MASK_W-1:0] maskQ;
  logic [7:0]        ctrlQ;
  logic [ADDR_W-1:0] startView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= {{(ADDR_W-8){1'b1}}, 8'h00};
      stopQ  <= '0;
      maskQ  <= MASK_W'(MASK_B0_SET);
      ctrlQ  <= CTRL_RESET;
    end else if (cfgWe) begin
      for (int b = 0; b < ADDR_BYTES; b++) begin
        if (cfgOffset == OFFS_W'(START_OFF + b))
          startQ[8*b +: 8] <= (b == 0) ? (cfgWdata & START_B0_KEEP) : cfgWdata;
        if (cfgOffset == OFFS_W'(STOP_OFF + b))
          stopQ[8*b +: 8] <= (b == 0) ? (cfgWdata & STOP_B0_KEEP) : cfgWdata;
      end
      for (int b = 0; b < MASK_BYTES; b++) begin
        if (cfgOffset == OFFS_W'(MASK_OFF + b))
          maskQ[8*b +: 8] <= (b == 0) ? (cfgWdata | MASK_B0_SET) : cfgWdata;
      end
      if (cfgOffset == OFFS_W'(CTRL_OFF))
        ctrlQ <= cfgWdata & CTRL_KEEP;
    end
  end

  // Width-select bit is only visible while the window decodes I/O.
  assign startView = {startQ[ADDR_W-1:1], startQ[0] & ~ctrlQ[CB_MEM]};

  always_comb begin
    cfgRdata = '0;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (cfgOffset == OFFS_W'(START_OFF + b)) cfgRdata = startView[8*b +: 8];
      if (cfgOffset == OFFS_W'(STOP_OFF + b))  cfgRdata = stopQ[8*b +: 8];
    end
    for (int b = 0; b < MASK_BYTES; b++) begin
      if (cfgOffset == OFFS_W'(MASK_OFF + b)) cfgRdata = maskQ[8*b +: 8];
    end
    if (cfgOffset == OFFS_W'(CTRL_OFF)) cfgRdata = ctrlQ;
  end

  always_comb begin
    cfg          = '0;
    cfg.start    = {startQ[ADDR_W-1:1], 1'b0};
    cfg.wideIo   = startQ[0];
    cfg.stop     = stopQ;
    cfg.mask     = maskQ;
    cfg.isMem    = ctrlQ[CB_MEM];
    cfg.toIsa    = ctrlQ[CB_ISA];
    cfg.prefetch = ctrlQ[CB_PREF];
    cfg.post     = ctrlQ[CB_POST];
    cfg.trap     = ctrlQ[CB_TRAP];
  end

  a_r3_mask_low_ones: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOffset == OFFS_W'(MASK_OFF)) |-> (cfgRdata[1:0] == 2'b11));
  a_r3_stop_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOffset == OFFS_W'(STOP_OFF)) |-> (cfgRdata[1:0] == 2'b00));
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOffset == OFFS_W'(CTRL_OFF)) |-> ((cfgRdata & ~CTRL_KEEP) == 8'h00));
  a_r2_ctrl_written: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgOffset == OFFS_W'(CTRL_OFF)) |=>
      (cfg.isMem == $past(cfgWdata[CB_MEM]) && cfg.trap == $past(cfgWdata[CB_TRAP])));
endmodule

// File: rtl/wdw_decode.sv
module wdw_decode
  import wdw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  win_cfg_t          cfg,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busIsMem,
  input  logic              busIsWrite,
  output logic              winHit,
  output logic              isaFwd,
  output logic              prefetchOk,
  output logic              postOk,
  output logic              trapReq
);
  logic [ADDR_W-1:0] keepBits;
  logic [ADDR_W-1:0] addrM, startM, stopM;
  logic              inRange, widthOk, typeOk, hitNow;

  always_comb begin
    keepBits = ~ADDR_W'(cfg.mask);
    addrM    = busAddr   & keepBits;
    startM   = cfg.start & keepBits;
    stopM    = cfg.stop  & keepBits;
    inRange  = (addrM >= startM) && (addrM <= stopM);
    widthOk  = cfg.isMem || cfg.wideIo || (busAddr[ADDR_W-1:NARROW_W] == '0);
    typeOk   = (busIsMem == cfg.isMem);
    hitNow   = busValid && typeOk && inRange && widthOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winHit     <= 1'b0;
      isaFwd     <= 1'b0;
      prefetchOk <= 1'b0;
      postOk     <= 1'b0;
      trapReq    <= 1'b0;
    end else begin
      winHit     <= hitNow;
      isaFwd     <= hitNow && cfg.toIsa;
      prefetchOk <= hitNow && cfg.isMem && cfg.prefetch && !busIsWrite;
      postOk     <= hitNow && cfg.isMem && cfg.post && busIsWrite;
      trapReq    <= hitNow && cfg.trap;
    end
  end

  a_r5_hit_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    winHit |-> $past(busValid));
  a_r8_type_matched: assert property (@(posedge clk) disable iff (!rstN)
    winHit |-> ($past(busIsMem) == $past(cfg.isMem)));
  a_r9_no_io_attrs: assert property (@(posedge clk) disable iff (!rstN)
    (prefetchOk || postOk) |-> $past(cfg.isMem));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(prefetchOk && postOk));
  a_r10_trap_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq || isaFwd) |-> winHit);
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import wdw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFFS_W-1:0] cfgOffset,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busIsMem,
  input  logic              busIsWrite,
  output logic              winHit,
  output logic              isaFwd,
  output logic              prefetchOk,
  output logic              postOk,
  output logic              trapReq
);
  win_cfg_t cfg;

  wdw_cfg_regs uRegs (
    .clk(clk), .rstN(rstN), .cfgOffset(cfgOffset), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .cfg(cfg)
  );

  wdw_decode uDec (
    .clk(clk), .rstN(rstN), .cfg(cfg), .busValid(busValid), .busAddr(busAddr),
    .busIsMem(busIsMem), .busIsWrite(busIsWrite), .winHit(winHit),
    .isaFwd(isaFwd), .prefetchOk(prefetchOk), .postOk(postOk), .trapReq(trapReq)
  );
endmodule

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cfgOffset = '0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgWdata = '0;
  logic [7:0]  cfgRdata;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busIsMem = 1'b0;
  logic        busIsWrite = 1'b0;
  logic        winHit, isaFwd, prefetchOk, postOk, trapReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  addr_window_decoder dut (
    .clk(clk), .rstN(rstN), .cfgOffset(cfgOffset), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .busValid(busValid), .busAddr(busAddr), .busIsMem(busIsMem),
    .busIsWrite(busIsWrite), .winHit(winHit), .isaFwd(isaFwd), .prefetchOk(prefetchOk),
    .postOk(postOk), .trapReq(trapReq)
  );

  // Behavioural reference: byte array plus decode rules from the requirements.
  logic [7:0] mr [16];
  logic [4:0] expQ;

  function automatic logic [7:0] modelRead(int o);
    if (o == 0) return {mr[0][7:2], 1'b0, mr[0][0] & ~mr[11][6]};
    if (o < 12) return mr[o];
    return 8'h00;
  endfunction

  function automatic logic [4:0] modelOut(logic v, logic [31:0] a, logic m, logic w);
    logic [31:0] lo, hi, mk;
    logic h;
    lo = {mr[3], mr[2], mr[1], mr[0]} & ~32'h3;
    hi = {mr[7], mr[6], mr[5], mr[4]};
    mk = {8'h00, mr[10], mr[9], mr[8]};
    h = v && (m == mr[11][6]) && ((a & ~mk) >= (lo & ~mk)) && ((a & ~mk) <= (hi & ~mk))
        && (mr[11][6] || mr[0][0] || a[31:16] == 16'h0);
    return {h, h && mr[11][7], h && m && mr[11][3] && !w, h && m && mr[11][2] && w,
            h && mr[11][0]};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mr[i] = 8'h00;
      mr[1] = 8'hFF; mr[2] = 8'hFF; mr[3] = 8'hFF; mr[8] = 8'h03; mr[11] = 8'h48;
      expQ <= '0;
    end else begin
      expQ <= modelOut(busValid, busAddr, busIsMem, busIsWrite);
      if (cfgWe && cfgOffset < 12) begin
        case (cfgOffset)
          4'd0:    mr[0]  = cfgWdata & 8'hFD;
          4'd4:    mr[4]  = cfgWdata & 8'hFC;
          4'd8:    mr[8]  = cfgWdata | 8'h03;
          4'd11:   mr[11] = cfgWdata & 8'hCD;
          default: mr[cfgOffset] = cfgWdata;
        endcase
      end
    end
  end

  // Every-clock comparison against the model (R5, R9, R10).
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if ({winHit, isaFwd, prefetchOk, postOk, trapReq} !== expQ) begin
        errors++;
        $display("FAIL R5/R9/R10 outputs {hit,isa,pref,post,trap} got %b expected %b at %0t",
                 {winHit, isaFwd, prefetchOk, postOk, trapReq}, expQ, $time);
      end
    end
  end

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int o, logic [7:0] d);
    @(negedge clk);
    cfgOffset = 4'(o); cfgWdata = d; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic rdCheck(int o, logic [7:0] exp, string tag);
    @(negedge clk);
    cfgOffset = 4'(o);
    #1;
    check(32'(cfgRdata), 32'(exp), tag);
    check(32'(cfgRdata), 32'(modelRead(o)), {tag, " model"});
  endtask

  task automatic wr32(int base, logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(base + b, v[8*b +: 8]);
  endtask

  // Offers one cycle; afterwards the registered result is visible.
  task automatic busCycle(logic [31:0] a, logic m, logic w, logic expHit, string tag);
    @(negedge clk);
    busValid = 1'b1; busAddr = a; busIsMem = m; busIsWrite = w;
    @(negedge clk);
    busValid = 1'b0;
    check(32'(winHit), 32'(expHit), tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rdCheck(0, 8'h00, "R1 start b0"); rdCheck(1, 8'hFF, "R1 start b1");
    rdCheck(2, 8'hFF, "R1 start b2"); rdCheck(3, 8'hFF, "R1 start b3");
    for (int o = 4; o < 8; o++) rdCheck(o, 8'h00, "R1 stop");
    rdCheck(8, 8'h03, "R1 mask b0"); rdCheck(9, 8'h00, "R1 mask b1");
    rdCheck(10, 8'h00, "R1 mask b2"); rdCheck(11, 8'h48, "R1 ctrl");
    for (int o = 12; o < 16; o++) rdCheck(o, 8'h00, "R1 reserved");
    busCycle(32'hFFFF_FF00, 1'b1, 1'b0, 1'b0, "R1 no hit out of reset");
    busCycle(32'h0000_0000, 1'b1, 1'b0, 1'b0, "R1 no hit at zero");

    // R2 reserved offsets ignore writes
    wr(13, 8'hFF); rdCheck(13, 8'h00, "R2 reserved offset");
    // R4 control layout
    wr(11, 8'hFF); rdCheck(11, 8'hCD, "R4 reserved ctrl bits");
    // R3 hard-wired low bits
    wr(8, 8'h00); rdCheck(8, 8'h03, "R3 mask low ones");
    wr(4, 8'hFF); rdCheck(4, 8'hFC, "R3 stop low zero");
    wr(0, 8'hFF); rdCheck(0, 8'hFC, "R7 width bit hidden in memory mode");

    // Memory window 1000_0000..1000_0FFF, all attributes on
    wr32(0, 32'h1000_0000); wr32(4, 32'h1000_0FFF);
    rdCheck(7, 8'h10, "R2 stop b3");
    busCycle(32'h1000_0000, 1'b1, 1'b0, 1'b1, "R5 lower bound");
    check(32'(prefetchOk), 1, "R9 prefetch on mem read");
    check(32'(isaFwd), 1, "R10 isa forward");
    check(32'(trapReq), 1, "R10 trap pulse");
    @(negedge clk);
    check(32'(trapReq), 0, "R10 trap single clock");
    busCycle(32'h1000_0FFC, 1'b1, 1'b1, 1'b1, "R5 upper bound");
    check(32'(postOk), 1, "R9 post on mem write");
    check(32'(prefetchOk), 0, "R9 no prefetch on write");
    busCycle(32'h0FFF_FFFC, 1'b1, 1'b0, 1'b0, "R5 below lower");
    busCycle(32'h1000_1000, 1'b1, 1'b0, 1'b0, "R5 above upper");
    busCycle(32'h1000_0800, 1'b0, 1'b0, 1'b0, "R8 I/O cycle to memory window");

    // R6 aliasing with mask bits 15:12
    wr(9, 8'hF0);
    busCycle(32'h1000_5800, 1'b1, 1'b0, 1'b1, "R6 aliased hit");
    busCycle(32'h1001_0800, 1'b1, 1'b0, 1'b0, "R6 unmasked bit differs");
    wr(10, 8'hFF);
    busCycle(32'h1100_0800, 1'b1, 1'b0, 1'b0, "R6 bits above 23 not maskable");
    wr(9, 8'h00); wr(10, 8'h00);

    // I/O window with attribute bits set: 0001_0300..0001_031F
    wr(11, 8'h0D);
    rdCheck(0, 8'h00, "R7 width bit visible, narrow");
    wr32(0, 32'h0001_0300); wr32(4, 32'h0001_031F);
    busCycle(32'h0001_0310, 1'b0, 1'b1, 1'b0, "R7 narrow decode needs high zero");
    wr(0, 8'h01);
    rdCheck(0, 8'h01, "R7 width bit reads back");
    busCycle(32'h0001_0310, 1'b0, 1'b1, 1'b1, "R7 wide decode hit");
    check(32'(postOk), 0, "R9 no post for I/O");
    busCycle(32'h0001_0310, 1'b0, 1'b0, 1'b1, "R5 I/O read hit");
    check(32'(prefetchOk), 0, "R9 no prefetch for I/O");
    busCycle(32'h0001_0310, 1'b1, 1'b0, 1'b0, "R8 memory cycle to I/O window");
    // narrow window in low space
    wr32(0, 32'h0000_0300); wr32(4, 32'h0000_031F);
    busCycle(32'h0000_031C, 1'b0, 1'b0, 1'b1, "R7 narrow decode hit");
    busCycle(32'h0000_0320, 1'b0, 1'b0, 1'b0, "R5 I/O above upper");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule